// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block walks a ring of transmit descriptors held in its own memory and turns each one that software marks as owned by hardware into a single frame request for a downstream frame sender. Each descriptor is two 32-bit words. The even word carries the frame length, the ownership flag and the per-frame options. The odd word carries the buffer address. Software fills the address and the length first. Setting the ready flag last passes the descriptor to the engine.

After the sender reports completion, the engine writes the result fields into the status word and clears ready, which returns the descriptor to software. If the descriptor asked for it, the engine also latches an interrupt source. It then moves to the next descriptor, or back to index 0 when the descriptor carries the wrap flag or is the last one of the transmit region. A count input sets how many descriptors at the bottom of the table belong to transmit. The rest of the table is left to a receive engine. A mode input starts and stops the walk.

Top module: `txd_walker`

## Requirements
- R1: After synchronous reset the engine sits at index 0, `snd_start` is low, `irq_src` is 00 and `irq` is low.
- R2: Descriptor i occupies host word 2i (status) and word 2i+1 (buffer address). The status word holds length in [31:16], ready in bit 15, interrupt enable in bit 14, wrap in bit 13, pad enable in bit 12 and CRC enable in bit 11.
- R3: When tx_en is high and the current descriptor has ready set, the engine raises `snd_start` for exactly one cycle. In that cycle `snd_len`, `snd_addr`, `snd_pad` and `snd_crc` carry that descriptor's fields. A descriptor whose ready bit is clear is never started, and the engine stays on it.
- R4: After `snd_done`, the status word is rewritten with ready cleared and bits [8:0] set to `snd_res`. The layout of `snd_res` is underrun in bit 8, retry count in [7:4], retry limit in bit 3, late collision in bit 2, defer in bit 1 and carrier lost in bit 0. Bits [31:16] and [14:9] and the address word keep their values.
- R5: After a descriptor with wrap set, the next descriptor used is index 0. Otherwise the engine moves to the next index.
- R6: The transmit region is min(tx_count, NUM_DESC) descriptors. After the last one the engine returns to index 0 even without wrap. A count of 0 starts no frame.
- R7: On completion of a descriptor with interrupt enable set, `irq_src` bit 0 (frame done) is set when the result has none of bits 8, 3, 2, 0. Otherwise bit 1 (frame error) is set. With interrupt enable clear, neither bit is set.
- R8: Source bits latch whatever the mask is. `irq` is the OR of `irq_src & irq_mask`. Writing a 1 through `irq_clr` clears that bit, and a new set in the same cycle wins.
- R9: While tx_en is low, no new frame is started. A frame already started still completes and is written back, and the walk resumes at the following index when tx_en returns.
- R10: A host write always takes effect. The engine's write-back waits while a host write is in progress and then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit walk enable |
| tx_count | input | CNT_W | Number of transmit descriptors (capped at NUM_DESC) |
| h_we | input | 1 | Host write strobe to descriptor memory |
| h_addr | input | AW | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after address |
| snd_start | output | 1 | One-cycle frame request |
| snd_len | output | 16 | Frame length |
| snd_addr | output | 32 | Frame buffer address |
| snd_pad | output | 1 | Pad short frame |
| snd_crc | output | 1 | Append CRC |
| snd_done | input | 1 | Frame completion pulse |
| snd_res | input | 9 | Completion result fields |
| irq_mask | input | 2 | Interrupt mask per source |
| irq_clr_we | input | 1 | Source clear strobe |
| irq_clr | input | 2 | Source bits to clear (write 1) |
| irq_src | output | 2 | Latched sources: bit 0 done, bit 1 error |
| irq | output | 1 | Masked interrupt request |

## Verification
Most internal faults show at the ports within one frame. A wrong index makes the next `snd_addr` differ from the expected buffer at the very next start. A bad write-back appears on the first host read of the status word after completion: ready is still set, the result bits are wrong or the length is damaged. A wrong error decode or a wrong interrupt-enable test shows on `irq_src` two cycles after `snd_done`. A fault in the enable or count gating shows as a start that appears when none is allowed, or as no start within a bounded wait.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int RES_W = 9;
    localparam logic [RES_W-1:0] ERR_BITS = 9'h10D;

    typedef struct packed {
        logic [15:0]      len;
        logic             rdy;
        logic             irq_en;
        logic             wrap;
        logic             pad;
        logic             crc;
        logic [1:0]       rsvd;
        logic [RES_W-1:0] res;
    } txd_stat_t;

    typedef enum logic [1:0] {
        ST_POLL,
        ST_ISSUE,
        ST_WAIT,
        ST_WB
    } txd_state_e;

    function automatic logic res_is_err(input logic [RES_W-1:0] r);
        return |(r & ERR_BITS);
    endfunction

    function automatic txd_stat_t close_stat(input txd_stat_t cur,
                                             input logic [RES_W-1:0] r);
        txd_stat_t s;
        s     = cur;
        s.rdy = 1'b0;
        s.res = r;
        return s;
    endfunction

endpackage

// File: rtl/txd_mem.sv
module txd_mem #(
    parameter int NUM_DESC = 128,
    localparam int IW = $clog2(NUM_DESC),
    localparam int AW = IW + 1,
    localparam int WORDS = 2 * NUM_DESC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  h_we,
    input  logic [AW-1:0]         h_addr,
    input  logic [31:0]           h_wdata,
    output logic [31:0]           h_rdata,
    input  logic [IW-1:0]         e_idx,
    output txd_pkg::txd_stat_t    e_stat,
    output logic [31:0]           e_addr,
    input  logic                  e_we,
    input  txd_pkg::txd_stat_t    e_wdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (h_we)
            mem[h_addr] <= h_wdata;
        else if (e_we)
            mem[{e_idx, 1'b0}] <= e_wdata;
        h_rdata <= mem[h_addr];
    end

    assign e_stat = txd_pkg::txd_stat_t'(mem[{e_idx, 1'b0}]);
    assign e_addr = mem[{e_idx, 1'b1}];

    // R4
    wb_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        e_we |-> !e_wdata.rdy);

    // R10
    no_collide_chk: assert property (@(posedge clk) disable iff (rst)
        e_we |-> !h_we);

endmodule

// File: rtl/txd_fsm.sv
module txd_fsm #(
    parameter int NUM_DESC = 128,
    localparam int IW = $clog2(NUM_DESC)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tx_en,
    input  logic [IW:0]                   cnt_eff,
    input  logic                          h_we,
    output logic [IW-1:0]                 idx,
    input  txd_pkg::txd_stat_t            e_stat,
    input  logic [31:0]                   e_addr,
    output logic                          e_we,
    output txd_pkg::txd_stat_t            e_wdata,
    output logic                          snd_start,
    output logic [15:0]                   snd_len,
    output logic [31:0]                   snd_addr,
    output logic                          snd_pad,
    output logic                          snd_crc,
    input  logic                          snd_done,
    input  logic [txd_pkg::RES_W-1:0]     snd_res,
    output logic                          set_ok,
    output logic                          set_err
);
    import txd_pkg::*;

    txd_state_e        state;
    logic [RES_W-1:0]  res_q;
    logic [IW:0]       idx_nxt_w;
    logic              at_end;
    logic              is_err;

    assign idx_nxt_w = {1'b0, idx} + 1'b1;
    assign at_end    = e_stat.wrap || (idx_nxt_w >= cnt_eff);
    assign is_err    = res_is_err(res_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_POLL;
            idx      <= '0;
            res_q    <= '0;
            snd_len  <= '0;
            snd_addr <= '0;
            snd_pad  <= 1'b0;
            snd_crc  <= 1'b0;
        end else begin
            case (state)
                ST_POLL: begin
                    if (tx_en && (cnt_eff != '0) && e_stat.rdy) begin
                        snd_len  <= e_stat.len;
                        snd_addr <= e_addr;
                        snd_pad  <= e_stat.pad;
                        snd_crc  <= e_stat.crc;
                        state    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (snd_done) begin
                        res_q <= snd_res;
                        state <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (!h_we) begin
                        idx   <= at_end ? '0 : idx_nxt_w[IW-1:0];
                        state <= ST_POLL;
                    end
                end
                default: state <= ST_POLL;
            endcase
        end
    end

    assign snd_start = (state == ST_ISSUE);
    assign e_we      = (state == ST_WB) && !h_we;
    assign e_wdata   = close_stat(e_stat, res_q);
    assign set_ok    = e_we && e_stat.irq_en && !is_err;
    assign set_err   = e_we && e_stat.irq_en && is_err;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        snd_start |=> !snd_start);

    // R9
    start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        snd_start |-> $past(tx_en));

    // R7
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        !(set_ok && set_err));

endmodule

// File: rtl/txd_irq.sv
module txd_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_ok,
    input  logic       set_err,
    input  logic       clr_we,
    input  logic [1:0] clr,
    input  logic [1:0] mask,
    output logic [1:0] src,
    output logic       irq
);
    logic [1:0] clr_eff;

    assign clr_eff = clr_we ? clr : 2'b00;

    always_ff @(posedge clk) begin
        if (rst)
            src <= 2'b00;
        else
            src <= (src & ~clr_eff) | {set_err, set_ok};
    end

    assign irq = |(src & mask);

    // R7
    src_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_ok |=> src[0]);

    // R8
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src[1] && !clr_eff[1]) |=> src[1]);

endmodule

// File: rtl/txd_walker.sv
module txd_walker #(
    parameter int NUM_DESC = 128,
    parameter int CNT_W = 8,
    localparam int IW = $clog2(NUM_DESC),
    localparam int AW = IW + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tx_en,
    input  logic [CNT_W-1:0]          tx_count,
    input  logic                      h_we,
    input  logic [AW-1:0]             h_addr,
    input  logic [31:0]               h_wdata,
    output logic [31:0]               h_rdata,
    output logic                      snd_start,
    output logic [15:0]               snd_len,
    output logic [31:0]               snd_addr,
    output logic                      snd_pad,
    output logic                      snd_crc,
    input  logic                      snd_done,
    input  logic [8:0]                snd_res,
    input  logic [1:0]                irq_mask,
    input  logic                      irq_clr_we,
    input  logic [1:0]                irq_clr,
    output logic [1:0]                irq_src,
    output logic                      irq
);
    import txd_pkg::*;

    localparam logic [31:0] CAP = 32'(NUM_DESC);

    logic [31:0]   cnt_wide;
    logic [IW:0]   cnt_eff;
    logic [IW-1:0] idx;
    txd_stat_t     e_stat;
    txd_stat_t     e_wdata;
    logic [31:0]   e_addr;
    logic          e_we;
    logic          set_ok;
    logic          set_err;

    assign cnt_wide = 32'(tx_count);
    assign cnt_eff  = (cnt_wide > CAP) ? CAP[IW:0] : cnt_wide[IW:0];

    txd_mem #(.NUM_DESC(NUM_DESC)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .h_we    (h_we),
        .h_addr  (h_addr),
        .h_wdata (h_wdata),
        .h_rdata (h_rdata),
        .e_idx   (idx),
        .e_stat  (e_stat),
        .e_addr  (e_addr),
        .e_we    (e_we),
        .e_wdata (e_wdata)
    );

    txd_fsm #(.NUM_DESC(NUM_DESC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .cnt_eff   (cnt_eff),
        .h_we      (h_we),
        .idx       (idx),
        .e_stat    (e_stat),
        .e_addr    (e_addr),
        .e_we      (e_we),
        .e_wdata   (e_wdata),
        .snd_start (snd_start),
        .snd_len   (snd_len),
        .snd_addr  (snd_addr),
        .snd_pad   (snd_pad),
        .snd_crc   (snd_crc),
        .snd_done  (snd_done),
        .snd_res   (snd_res),
        .set_ok    (set_ok),
        .set_err   (set_err)
    );

    txd_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_ok  (set_ok),
        .set_err (set_err),
        .clr_we  (irq_clr_we),
        .clr     (irq_clr),
        .mask    (irq_mask),
        .src     (irq_src),
        .irq     (irq)
    );

endmodule

// File: tb/sim_txd_walker.sv
`timescale 1ns/1ps
module sim_txd_walker;

    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic [7:0]  tx_count = 8'd4;
    logic        h_we = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        snd_start;
    logic [15:0] snd_len;
    logic [31:0] snd_addr;
    logic        snd_pad;
    logic        snd_crc;
    logic        snd_done = 1'b0;
    logic [8:0]  snd_res = '0;
    logic [1:0]  irq_mask = 2'b00;
    logic        irq_clr_we = 1'b0;
    logic [1:0]  irq_clr = 2'b00;
    logic [1:0]  irq_src;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    txd_walker u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_count(tx_count),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .snd_start(snd_start), .snd_len(snd_len), .snd_addr(snd_addr),
        .snd_pad(snd_pad), .snd_crc(snd_crc), .snd_done(snd_done),
        .snd_res(snd_res), .irq_mask(irq_mask), .irq_clr_we(irq_clr_we),
        .irq_clr(irq_clr), .irq_src(irq_src), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic [15:0] len, input logic ie,
                                       input logic wr, input logic pd,
                                       input logic cr, input logic rdy);
        return {len, rdy, ie, wr, pd, cr, 11'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic hread(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        h_addr = a;
        @(negedge clk);
        d = h_rdata;
    endtask

    task automatic wait_start(input int lim, output bit seen);
        seen = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (snd_start) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic finish_frame(input logic [8:0] r);
        @(negedge clk);
        snd_done = 1'b1; snd_res = r;
        @(negedge clk);
        snd_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        tx_en = 1'b0; rst = 1'b1; irq_clr_we = 1'b0; irq_mask = 2'b00;
        snd_done = 1'b0; tx_count = 8'd4;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) hwrite(AW'(2 * i), 32'h0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 start", {31'b0, snd_start}, 32'd0);
        chk("R1 src", {30'b0, irq_src}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_basic();
        bit s; logic [31:0] d;
        do_reset();
        irq_mask = 2'b01;
        hwrite(1, 32'hA000_0000);
        hwrite(0, mk(16'd100, 1, 0, 1, 0, 1));
        tx_en = 1'b1;
        wait_start(40, s);
        chk("R3 start seen", {31'b0, s}, 32'd1);
        chk("R2 len", {16'b0, snd_len}, 32'd100);
        chk("R2 addr", snd_addr, 32'hA000_0000);
        chk("R2 pad/crc", {30'b0, snd_pad, snd_crc}, 32'd2);
        finish_frame(9'h020);
        hread(0, d);
        chk("R4 status wb", d, mk(16'd100, 1, 0, 1, 0, 0) | 32'h020);
        hread(1, d);
        chk("R4 addr kept", d, 32'hA000_0000);
        chk("R7 done src", {30'b0, irq_src}, 32'd1);
        chk("R8 irq", {31'b0, irq}, 32'd1);
        @(negedge clk); irq_clr_we = 1'b1; irq_clr = 2'b01;
        @(negedge clk); irq_clr_we = 1'b0;
        chk("R8 clear", {30'b0, irq_src, irq}, 32'd0);
    endtask

    task automatic t_notready();
        bit s; logic [31:0] d;
        do_reset();
        irq_mask = 2'b01;
        hwrite(1, 32'hB000_0000);
        hwrite(0, mk(16'd60, 1, 0, 0, 1, 0));
        tx_en = 1'b1;
        wait_start(20, s);
        chk("R3 not ready no start", {31'b0, s}, 32'd0);
        hread(0, d);
        chk("R3 untouched", d, mk(16'd60, 1, 0, 0, 1, 0));
        hwrite(0, mk(16'd60, 1, 0, 0, 1, 1));
        wait_start(40, s);
        chk("R3 ready start", {31'b0, s}, 32'd1);
        chk("R3 addr", snd_addr, 32'hB000_0000);
        finish_frame(9'h100);
        chk("R7 err src", {30'b0, irq_src}, 32'd2);
        chk("R8 masked", {31'b0, irq}, 32'd0);
        @(negedge clk); irq_mask = 2'b11;
        @(negedge clk);
        chk("R8 unmasked", {31'b0, irq}, 32'd1);
        @(negedge clk); irq_clr_we = 1'b1; irq_clr = 2'b10;
        @(negedge clk); irq_clr_we = 1'b0;
        chk("R8 w1c", {30'b0, irq_src}, 32'd0);
    endtask

    task automatic t_noirq();
        bit s; logic [31:0] d;
        do_reset();
        hwrite(1, 32'hC000_0000);
        hwrite(0, mk(16'd70, 0, 0, 0, 0, 1));
        tx_en = 1'b1;
        wait_start(40, s);
        finish_frame(9'h008);
        chk("R7 no irq", {30'b0, irq_src}, 32'd0);
        hread(0, d);
        chk("R4 wb no irq", d, mk(16'd70, 0, 0, 0, 0, 0) | 32'h008);
    endtask

    task automatic t_wrap();
        bit s;
        do_reset();
        hwrite(1, 32'hA0); hwrite(3, 32'hA1); hwrite(5, 32'hA2);
        hwrite(0, mk(16'd64, 0, 0, 0, 0, 1));
        hwrite(2, mk(16'd64, 0, 1, 0, 0, 1));
        tx_en = 1'b1;
        wait_start(40, s);
        chk("R5 first", snd_addr, 32'hA0);
        finish_frame(9'h0);
        wait_start(40, s);
        chk("R5 second", snd_addr, 32'hA1);
        finish_frame(9'h0);
        hwrite(4, mk(16'd64, 0, 0, 0, 0, 1));
        hwrite(0, mk(16'd64, 0, 0, 0, 0, 1));
        wait_start(40, s);
        chk("R5 wrapped", snd_addr, 32'hA0);
        finish_frame(9'h0);
    endtask

    task automatic t_count();
        bit s;
        do_reset();
        tx_count = 8'd2;
        hwrite(1, 32'hD0); hwrite(3, 32'hD1); hwrite(5, 32'hD2);
        hwrite(0, mk(16'd64, 0, 0, 0, 0, 1));
        hwrite(2, mk(16'd64, 0, 0, 0, 0, 1));
        hwrite(4, mk(16'd64, 0, 0, 0, 0, 1));
        tx_en = 1'b1;
        wait_start(40, s); chk("R6 d0", snd_addr, 32'hD0); finish_frame(9'h0);
        wait_start(40, s); chk("R6 d1", snd_addr, 32'hD1); finish_frame(9'h0);
        wait_start(20, s);
        chk("R6 stays in region", {31'b0, s}, 32'd0);
        hwrite(0, mk(16'd64, 0, 0, 0, 0, 1));
        wait_start(40, s);
        chk("R6 back to 0", snd_addr, 32'hD0);
        finish_frame(9'h0);
        do_reset();
        tx_count = 8'd0;
        hwrite(0, mk(16'd64, 0, 0, 0, 0, 1));
        tx_en = 1'b1;
        wait_start(20, s);
        chk("R6 zero count", {31'b0, s}, 32'd0);
    endtask

    task automatic t_enable();
        bit s; logic [31:0] d;
        do_reset();
        hwrite(1, 32'hE0); hwrite(3, 32'hE1);
        hwrite(0, mk(16'd80, 0, 0, 0, 0, 1));
        hwrite(2, mk(16'd81, 0, 0, 0, 0, 1));
        tx_en = 1'b1;
        wait_start(40, s);
        chk("R9 first", snd_addr, 32'hE0);
        tx_en = 1'b0;
        finish_frame(9'h0);
        hread(0, d);
        chk("R9 inflight wb", d, mk(16'd80, 0, 0, 0, 0, 0));
        wait_start(20, s);
        chk("R9 no new start", {31'b0, s}, 32'd0);
        tx_en = 1'b1;
        wait_start(40, s);
        chk("R9 resume", snd_addr, 32'hE1);
        finish_frame(9'h0);
    endtask

    task automatic t_collide();
        bit s; logic [31:0] d;
        do_reset();
        irq_mask = 2'b11;
        hwrite(1, 32'hF0);
        hwrite(0, mk(16'd90, 1, 0, 0, 0, 1));
        tx_en = 1'b1;
        wait_start(40, s);
        @(negedge clk);
        snd_done = 1'b1; snd_res = 9'h004;
        h_we = 1'b1; h_addr = 8'd10; h_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        snd_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 wb deferred", {30'b0, irq_src}, 32'd0);
        h_we = 1'b0;
        repeat (3) @(negedge clk);
        hread(0, d);
        chk("R10 wb done", d, mk(16'd90, 1, 0, 0, 0, 0) | 32'h004);
        hread(10, d);
        chk("R10 host write", d, 32'hDEAD_BEEF);
        chk("R7 lc error", {30'b0, irq_src}, 32'd2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_notready();
        t_noirq();
        t_wrap();
        t_count();
        t_enable();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule